// File: doc/BRIEF.md
# DCC Track H-Bridge Output Sequencer

This block turns a serial DCC bit stream into the gate controls of a full H-bridge that feeds the track. It also drives a two-wire secondary bus transmitter from the same stream. Neighbouring logic produces the bit values, the bit-slot timing and the current-sense verdict. It delivers them as a one-cycle slot tick, a main-track bit, a programming-track bit, a cutout flag and an overload flag. The sequencer decides which pair of bridge switches conducts during each slot.

At every slot tick the bridge first goes fully off for a configurable dead time, then turns on the new diagonal pair. This way no leg ever has both of its switches conducting. In main-line operation the bridge follows the main-track bit. If the cutout feature is enabled and the cutout flag is set, it shorts the rails through both low-side switches instead. In service operation it follows the programming-track bit, but only while the service sequencer reports that it is active. An overload verdict overrides everything and holds the bridge off.

Top module: `dcc_bridge_sequencer`

## Requirements
- R1: While reset is asserted and after it is released with no slot tick, all four bridge controls are 0, `tx_lo` is 1 and `tx_hi` is 0.
- R2: A slot tick sampled at a clock edge drives all four bridge controls to 0 for DEAD_CYCLES cycles (default 1). The newly selected pair is then applied on the following edge. The bridge never moves from one non-zero pattern to another without passing through all-off.
- R3: A bit of 1 turns on `a_lo` and `b_hi`, and a bit of 0 turns on `a_hi` and `b_lo`. `a_lo`/`a_hi` are never both 1, and `b_lo`/`b_hi` are never both 1.
- R4: One cycle after `overload` is sampled high, all four bridge controls are 0. They stay 0 while it remains high, and slot ticks in that time have no effect on the bridge or the transmitter lines. After release, the bridge stays off until the next slot tick.
- R5: With `svc_mode`=1 and `svc_active`=1, the applied pair follows `prog_bit`. `main_bit` and `cutout` have no effect.
- R6: With `svc_mode`=1 and `svc_active`=0, a slot tick leaves all four bridge controls at 0.
- R7: In main-line operation (`svc_mode`=0) with `railcom_en`=1 and `cutout`=1, the applied pattern is `a_lo`=1, `b_lo`=1, `a_hi`=0, `b_hi`=0. With `railcom_en`=0 the cutout flag is ignored and `main_bit` selects the pair.
- R8: In main-line operation with `tx_enable`=1, a slot tick clears both transmitter lines for the dead time. Then `tx_lo`=`main_bit` and `tx_hi`=not `main_bit`. In service operation, or with `tx_enable`=0, both lines keep their previous values.
- R9: Apart from the overload force-off, the bridge outputs change only as the result of a slot tick. Input changes between ticks leave them untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One-cycle pulse at the start of each bit slot |
| main_bit | input | 1 | Main-track DCC bit for the coming slot |
| prog_bit | input | 1 | Programming-track DCC bit for the coming slot |
| cutout | input | 1 | Cutout window active for the coming slot |
| overload | input | 1 | Current-sense fault; forces the bridge off |
| svc_mode | input | 1 | 1 = service (programming) operation, 0 = main-line operation |
| tx_enable | input | 1 | Enables the secondary bus transmitter in main-line operation |
| railcom_en | input | 1 | Enables the cutout rail short |
| svc_active | input | 1 | Service sequencer is past its idle state |
| a_lo | output | 1 | Leg A low-side switch |
| a_hi | output | 1 | Leg A high-side switch |
| b_lo | output | 1 | Leg B low-side switch |
| b_hi | output | 1 | Leg B high-side switch |
| tx_lo | output | 1 | Secondary bus low line |
| tx_hi | output | 1 | Secondary bus high line |

## Verification
The vector walk runs main-line slots of both bit values with the transmitter on and off. This separates the bit encoding from the transmitter hold behaviour. Cutout slots are run with the feature enabled and disabled, to show that the enable and not the flag alone selects the rail short. Service slots are run with the active state set and cleared, and with contradicting main-bit and cutout inputs, to show which bit source is used. Directed runs hold inputs steady between ticks, raise overload mid-slot, during a tick and inside the dead time, and check that release does not re-enable the bridge until the next slot.

// File: rtl/dcc_seq_pkg.sv
package dcc_seq_pkg;

   typedef struct packed {
      logic a_lo;
      logic a_hi;
      logic b_lo;
      logic b_hi;
   } bridge_t;

   localparam bridge_t BRIDGE_OFF = '{a_lo: 1'b0, a_hi: 1'b0, b_lo: 1'b0, b_hi: 1'b0};

   typedef enum logic [1:0] {
      SRC_OFF    = 2'd0,
      SRC_MAIN   = 2'd1,
      SRC_PROG   = 2'd2,
      SRC_CUTOUT = 2'd3
   } drive_src_e;

   // Diagonal pair for a data bit: 1 -> A low + B high, 0 -> A high + B low
   function automatic bridge_t bit_pair(input logic b);
      bridge_t p;
      p.a_lo = b;
      p.b_hi = b;
      p.a_hi = ~b;
      p.b_lo = ~b;
      return p;
   endfunction

   function automatic bridge_t rail_short();
      bridge_t p;
      p = BRIDGE_OFF;
      p.a_lo = 1'b1;
      p.b_lo = 1'b1;
      return p;
   endfunction

endpackage

// File: rtl/dcc_slot_selector.sv
module dcc_slot_selector
   import dcc_seq_pkg::*;
#(
   parameter bit RAILCOM_SUPPORT = 1'b1,
   parameter bit TX_SUPPORT      = 1'b1
) (
   input  logic    svc_mode,
   input  logic    svc_active,
   input  logic    main_bit,
   input  logic    prog_bit,
   input  logic    cutout,
   input  logic    railcom_en,
   input  logic    tx_enable,
   output bridge_t next_bridge,
   output logic    tx_drive,
   output logic    tx_lo_next,
   output logic    tx_hi_next
);

   logic       cutout_gate;
   drive_src_e src;

   generate
      if (RAILCOM_SUPPORT) begin : g_cutout
         assign cutout_gate = railcom_en & cutout;
      end else begin : g_no_cutout
         assign cutout_gate = 1'b0;
      end
   endgenerate

   generate
      if (TX_SUPPORT) begin : g_tx
         assign tx_drive = ~svc_mode & tx_enable;
      end else begin : g_no_tx
         assign tx_drive = 1'b0;
      end
   endgenerate

   assign tx_lo_next = main_bit;
   assign tx_hi_next = ~main_bit;

   always_comb begin
      if (svc_mode) begin
         src = svc_active ? SRC_PROG : SRC_OFF;
      end else if (cutout_gate) begin
         src = SRC_CUTOUT;
      end else begin
         src = SRC_MAIN;
      end
   end

   always_comb begin
      case (src)
         SRC_MAIN:   next_bridge = bit_pair(main_bit);
         SRC_PROG:   next_bridge = bit_pair(prog_bit);
         SRC_CUTOUT: next_bridge = rail_short();
         default:    next_bridge = BRIDGE_OFF;
      endcase
   end

endmodule

// File: rtl/dcc_deadtime_stage.sv
module dcc_deadtime_stage
   import dcc_seq_pkg::*;
#(
   parameter int DEAD_CYCLES = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    slot_tick,
   input  logic    overload,
   input  bridge_t next_bridge,
   output bridge_t bridge_q,
   output logic    capture,
   output logic    apply
);

   localparam int CW = $clog2(DEAD_CYCLES + 1);
   localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYCLES);
   localparam logic [CW-1:0] CNT_ONE   = CW'(1);

   bridge_t         pend_q;
   logic [CW-1:0]   cnt_q;

   assign capture = slot_tick & ~overload;
   assign apply   = ~overload & ~slot_tick & (cnt_q == CNT_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bridge_q <= BRIDGE_OFF;
         pend_q   <= BRIDGE_OFF;
         cnt_q    <= '0;
      end else if (overload) begin
         bridge_q <= BRIDGE_OFF;
         cnt_q    <= '0;
      end else if (slot_tick) begin
         bridge_q <= BRIDGE_OFF;
         pend_q   <= next_bridge;
         cnt_q    <= DEAD_LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_ONE;
         if (cnt_q == CNT_ONE) begin
            bridge_q <= pend_q;
         end
      end
   end

endmodule

// File: rtl/dcc_tx_line_driver.sv
module dcc_tx_line_driver (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic apply,
   input  logic tx_drive,
   input  logic tx_lo_next,
   input  logic tx_hi_next,
   output logic tx_lo_q,
   output logic tx_hi_q
);

   logic pend_drive_q;
   logic pend_lo_q;
   logic pend_hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_lo_q      <= 1'b1;
         tx_hi_q      <= 1'b0;
         pend_drive_q <= 1'b0;
         pend_lo_q    <= 1'b0;
         pend_hi_q    <= 1'b0;
      end else if (capture) begin
         pend_drive_q <= tx_drive;
         pend_lo_q    <= tx_lo_next;
         pend_hi_q    <= tx_hi_next;
         if (tx_drive) begin
            tx_lo_q <= 1'b0;
            tx_hi_q <= 1'b0;
         end
      end else if (apply && pend_drive_q) begin
         tx_lo_q <= pend_lo_q;
         tx_hi_q <= pend_hi_q;
      end
   end

endmodule

// File: rtl/dcc_bridge_sequencer.sv
module dcc_bridge_sequencer
   import dcc_seq_pkg::*;
#(
   parameter int DEAD_CYCLES     = 1,
   parameter bit RAILCOM_SUPPORT = 1'b1,
   parameter bit TX_SUPPORT      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_tick,
   input  logic main_bit,
   input  logic prog_bit,
   input  logic cutout,
   input  logic overload,
   input  logic svc_mode,
   input  logic tx_enable,
   input  logic railcom_en,
   input  logic svc_active,
   output logic a_lo,
   output logic a_hi,
   output logic b_lo,
   output logic b_hi,
   output logic tx_lo,
   output logic tx_hi
);

   generate
      if (DEAD_CYCLES < 1) begin : g_bad_dead
         $error("DEAD_CYCLES must be at least 1");
      end
   endgenerate

   bridge_t next_bridge;
   bridge_t bridge_q;
   logic    tx_drive;
   logic    tx_lo_next;
   logic    tx_hi_next;
   logic    capture;
   logic    apply;

   dcc_slot_selector #(
      .RAILCOM_SUPPORT (RAILCOM_SUPPORT),
      .TX_SUPPORT      (TX_SUPPORT)
   ) u_sel (
      .svc_mode    (svc_mode),
      .svc_active  (svc_active),
      .main_bit    (main_bit),
      .prog_bit    (prog_bit),
      .cutout      (cutout),
      .railcom_en  (railcom_en),
      .tx_enable   (tx_enable),
      .next_bridge (next_bridge),
      .tx_drive    (tx_drive),
      .tx_lo_next  (tx_lo_next),
      .tx_hi_next  (tx_hi_next)
   );

   dcc_deadtime_stage #(
      .DEAD_CYCLES (DEAD_CYCLES)
   ) u_dead (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_tick   (slot_tick),
      .overload    (overload),
      .next_bridge (next_bridge),
      .bridge_q    (bridge_q),
      .capture     (capture),
      .apply       (apply)
   );

   dcc_tx_line_driver u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (capture),
      .apply      (apply),
      .tx_drive   (tx_drive),
      .tx_lo_next (tx_lo_next),
      .tx_hi_next (tx_hi_next),
      .tx_lo_q    (tx_lo),
      .tx_hi_q    (tx_hi)
   );

   assign a_lo = bridge_q.a_lo;
   assign a_hi = bridge_q.a_hi;
   assign b_lo = bridge_q.b_lo;
   assign b_hi = bridge_q.b_hi;

endmodule

// File: rtl/dcc_bridge_sequencer_chk.sv
module dcc_bridge_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic slot_tick,
   input logic overload,
   input logic a_lo,
   input logic a_hi,
   input logic b_lo,
   input logic b_hi,
   input logic tx_lo,
   input logic tx_hi
);

   logic [3:0] br;
   assign br = {a_lo, a_hi, b_lo, b_hi};

   // R3: leg A shoot-through
   a_r3_leg_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_lo && a_hi));

   // R3: leg B shoot-through
   a_r3_leg_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_lo && b_hi));

   // R2: every new non-zero pattern is entered from all-off
   a_r2_enter_from_off: assert property (@(posedge clk) disable iff (!rst_n)
      (br != 4'b0000 && br != $past(br)) |-> ($past(br) == 4'b0000));

   // R4: overload seen on one edge forces all-off on the next
   a_r4_overload_off: assert property (@(posedge clk) disable iff (!rst_n)
      overload |=> (br == 4'b0000));

   // R9: a conducting pattern is left only on a tick or an overload
   a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(br) != 4'b0000 && br != $past(br)) |-> ($past(slot_tick) || $past(overload)));

   // R8: secondary bus lines never both asserted
   a_r8_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_lo && tx_hi));

endmodule

bind dcc_bridge_sequencer dcc_bridge_sequencer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slot_tick (slot_tick),
   .overload  (overload),
   .a_lo      (a_lo),
   .a_hi      (a_hi),
   .b_lo      (b_lo),
   .b_hi      (b_hi),
   .tx_lo     (tx_lo),
   .tx_hi     (tx_hi)
);

// File: tb/dcc_bridge_sequencer_bench.sv
module dcc_bridge_sequencer_bench;

   logic clk = 1'b0;
   logic rst_n;
   logic slot_tick, main_bit, prog_bit, cutout, overload;
   logic svc_mode, tx_enable, railcom_en, svc_active;
   logic a_lo, a_hi, b_lo, b_hi, tx_lo, tx_hi;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   dcc_bridge_sequencer u_dcc_bridge_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_tick  (slot_tick),
      .main_bit   (main_bit),
      .prog_bit   (prog_bit),
      .cutout     (cutout),
      .overload   (overload),
      .svc_mode   (svc_mode),
      .tx_enable  (tx_enable),
      .railcom_en (railcom_en),
      .svc_active (svc_active),
      .a_lo       (a_lo),
      .a_hi       (a_hi),
      .b_lo       (b_lo),
      .b_hi       (b_hi),
      .tx_lo      (tx_lo),
      .tx_hi      (tx_hi)
   );

   // Vector: {svc_mode, svc_active, tx_enable, railcom_en, cutout, main_bit, prog_bit,
   //          expected {a_lo,a_hi,b_lo,b_hi}, transmitter driven}
   localparam int NV = 10;
   localparam logic [11:0] VEC [NV] = '{
      12'b0010010_1001_1,  // R3 main bit 1, R8 driven
      12'b0010000_0110_1,  // R3 main bit 0, R8 driven
      12'b0000010_1001_0,  // R8 transmitter off: hold
      12'b0011110_1010_1,  // R7 cutout shorts rails
      12'b0010100_0110_1,  // R7 cutout ignored when disabled
      12'b0001010_1001_0,  // R7 enabled, flag clear
      12'b1110001_1001_0,  // R5 prog bit 1, main bit 0 ignored
      12'b1101110_0110_0,  // R5 prog bit 0, main bit and cutout ignored
      12'b1010001_0000_0,  // R6 service idle: off
      12'b0010001_0110_1   // R3 main bit 0 with prog bit 1
   };

   logic exp_tx_lo, exp_tx_hi;

   function automatic logic [3:0] br_now();
      return {a_lo, a_hi, b_lo, b_hi};
   endfunction

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic set_inputs(input logic [6:0] s);
      {svc_mode, svc_active, tx_enable, railcom_en, cutout, main_bit, prog_bit} = s;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; slot_tick = 1'b0; overload = 1'b0;
      set_inputs(7'b0);
      exp_tx_lo = 1'b1; exp_tx_hi = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 in reset", {br_now(), tx_lo, tx_hi}, 6'b0000_10);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after reset", {br_now(), tx_lo, tx_hi}, 6'b0000_10);

      // Vector walk: tick, check dead slot, check applied pattern
      for (int i = 0; i < NV; i++) begin
         logic [11:0] v;
         v = VEC[i];
         set_inputs(v[11:5]);
         slot_tick = 1'b1;
         @(negedge clk);
         slot_tick = 1'b0;
         if (v[0]) check("R2/R8 dead slot", {br_now(), tx_lo, tx_hi}, 6'b0000_00);
         else      check("R2 dead slot", {br_now(), tx_lo, tx_hi}, {4'b0000, exp_tx_lo, exp_tx_hi});
         @(negedge clk);
         if (v[0]) begin
            exp_tx_lo = v[6];
            exp_tx_hi = ~v[6];
         end
         check("R3/R5/R6/R7/R8 applied", {br_now(), tx_lo, tx_hi}, {v[4:1], exp_tx_lo, exp_tx_hi});
      end

      // R9: inputs change between ticks, bridge holds 0110
      set_inputs(7'b0011110);
      repeat (4) @(negedge clk);
      check("R9 no tick", {br_now(), tx_lo, tx_hi}, {4'b0110, exp_tx_lo, exp_tx_hi});

      // Set up a bit-1 slot with the transmitter driven
      set_inputs(7'b0010010);
      slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0; @(negedge clk);
      check("R3 before overload", {br_now(), tx_lo, tx_hi}, 6'b1001_10);

      // R4: overload mid-slot
      overload = 1'b1;
      @(negedge clk);
      check("R4 overload off", {br_now(), tx_lo, tx_hi}, 6'b0000_10);
      set_inputs(7'b0010000);
      slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0; @(negedge clk);
      check("R4 tick ignored", {br_now(), tx_lo, tx_hi}, 6'b0000_10);
      overload = 1'b0;
      repeat (3) @(negedge clk);
      check("R4 stays off after release", {br_now(), tx_lo, tx_hi}, 6'b0000_10);
      slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0; @(negedge clk);
      check("R4 resumes on tick", {br_now(), tx_lo, tx_hi}, 6'b0110_01);

      // R4: overload inside the dead slot
      set_inputs(7'b0000010);
      slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0;
      overload = 1'b1;
      @(negedge clk);
      check("R4 overload in dead slot", br_now(), 4'b0000);
      overload = 1'b0;
      repeat (2) @(negedge clk);
      check("R4 dead slot not applied", {br_now(), tx_lo, tx_hi}, 6'b0000_01);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule